// File: doc/BRIEF.md
# Multicore Boot Release Table

After reset, every secondary processor core in a cluster waits on a slot in a small memory-mapped table. Each core owns one 32-byte slot. Boot software fills in a slot with the entry address and the argument for that core. When the 64-bit entry-address field of a slot ends with bit 0 clear, the table releases the core. It issues a one-cycle pulse on that core's release line, together with the release payload. The payload holds the start offset inside a 64 MiB window, the window base, the window size, a page-size code for that window and the argument value.

Bus accesses are 1, 2 or 4 bytes wide, and multi-byte values use big-endian byte order. The primary core (slot 0) never waits, so writes to its slot are dropped. Writes to slots at or above the number of cores present are dropped too. Any slot can be read at any time. When a core is released, its hardware identifier is copied into its slot, so software can see which physical core took the slot.

Top module: `brt_boot_release_table`

## Requirements
- R1: After reset, every slot i reads back entry address 1, argument i, identifier i, and zero in the reserved word and the padding.
- R2: A read (bus_req=1, bus_we=0) returns its data on bus_rdata with bus_rvalid=1 in the next cycle. The data is right-aligned and big-endian: the byte at the lowest offset is the most significant byte. bus_size encodes 0=1 byte, 1=2 bytes, 2=4 bytes. Address bits below the access size are ignored.
- R3: An accepted write stores its bytes big-endian at the aligned offset and touches no other byte of the slot.
- R4: bus_addr[9:5] selects the slot and bus_addr[4:0] the byte in it. The slot layout is: entry address in bytes 0-7, argument in bytes 8-15, reserved word in bytes 16-19, identifier in bytes 20-23, padding in bytes 24-31.
- R5: A write to slot 0 changes no stored byte and releases nothing.
- R6: A write to a slot whose index is at or above cores_present changes no stored byte and releases nothing.
- R7: One cycle after an accepted write that leaves bit 0 of the slot's entry address clear, exactly the matching bit of rel_pulse is high for one cycle. This bit 0 is bit 0 of byte 7.
- R8: With a pulse, the payload is as follows. rel_start is the entry address ANDed with 2^26-1. rel_map_base is the entry address with bits 25:0 cleared. rel_map_size is 2^26. rel_arg is the argument field. rel_page_code is 8, which is half the index of the lowest set bit of the size divided by 1024.
- R9: On a release, the identifier field of the slot is replaced by that core's value on core_ident[32*i+31:32*i].
- R10: Once a core has been released, it is not released again until a write sets bit 0 of its entry address. After that, a later write that clears the bit releases it again.
- R11: bus_size=3 stores nothing and releases nothing. A read with bus_size=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset into the table |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_wdata | input | 32 | Right-aligned write value |
| bus_rdata | output | 32 | Right-aligned read value |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| cores_present | input | 6 | Number of cores present |
| core_ident | input | 1024 | Hardware identifier of each core, 32 bits each |
| rel_pulse | output | 32 | One-cycle release pulse per core |
| rel_start | output | 64 | Start offset inside the window |
| rel_arg | output | 64 | Argument for the released core |
| rel_map_base | output | 64 | 64 MiB-aligned window base |
| rel_map_size | output | 64 | Window size |
| rel_page_code | output | 4 | Page-size code of the window |

## Verification
Read data and the release pulse with its payload both come out of a single register stage. Each is therefore due exactly one cycle after the request cycle. The identifier write-back is visible to the first read issued after the release cycle. The bench drives each access on a falling edge and holds it across one rising edge. It samples bus_rdata, bus_rvalid, rel_pulse and the payload on the next falling edge. It then compares them with a byte-level model of the table that is updated in the same task. Because of this, a pulse that comes a cycle early, comes a cycle late or lasts two cycles shows up as a mismatch.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int SLOT_BYTES = 32;
    localparam int SLOT_BITS  = SLOT_BYTES * 8;
    localparam int SLOT_OFF_W = $clog2(SLOT_BYTES);
    localparam int WIN_SHIFT  = 26;
    localparam logic [63:0] WIN_SIZE = 64'd1 << WIN_SHIFT;
    localparam logic [63:0] WIN_MASK = WIN_SIZE - 64'd1;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_BAD  = 2'd3
    } xfer_size_e;

    // Field order is the byte order of a slot: the first field sits at byte 0.
    typedef struct packed {
        logic [63:0] entry_addr;
        logic [63:0] arg;
        logic [31:0] resv;
        logic [31:0] ident;
        logic [63:0] pad;
    } slot_t;

    typedef struct packed {
        logic [63:0] start;
        logic [63:0] arg;
        logic [63:0] map_base;
        logic [63:0] map_size;
        logic [3:0]  page_code;
    } launch_t;

    function automatic int xfer_bytes(input xfer_size_e s);
        case (s)
            XFER_BYTE: return 1;
            XFER_HALF: return 2;
            XFER_WORD: return 4;
            default:   return 0;
        endcase
    endfunction

    // Half the index of the lowest set bit of (size / 1024).
    function automatic logic [3:0] page_code(input logic [63:0] sz);
        logic [63:0] kb;
        int low;
        kb  = sz >> 10;
        low = 0;
        for (int b = 63; b >= 0; b--) begin
            if (kb[b]) low = b;
        end
        return 4'(low >> 1);
    endfunction

    function automatic slot_t slot_init(input int idx);
        slot_t s;
        s            = '0;
        s.entry_addr = 64'd1;
        s.arg        = 64'(idx);
        s.ident      = 32'(idx);
        return s;
    endfunction

    function automatic logic [7:0] slot_byte(input slot_t s, input int k);
        logic [SLOT_BITS-1:0] v;
        v = s;
        return v[SLOT_BITS-1-8*k -: 8];
    endfunction

endpackage

// File: rtl/brt_bus_decode.sv
module brt_bus_decode
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int IDX_W     = 5,
    parameter int ADDR_W    = IDX_W + SLOT_OFF_W
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            size,
    input  logic [31:0]           wdata,
    output logic [IDX_W-1:0]      slot_idx,
    output logic                  slot_ok,
    output logic [SLOT_OFF_W-1:0] off_al,
    output logic [2:0]            nbytes,
    output logic [SLOT_BYTES-1:0] byte_en,
    output logic [SLOT_BITS-1:0]  byte_val
);

    int nb;

    always_comb begin
        nb       = xfer_bytes(xfer_size_e'(size));
        nbytes   = 3'(nb);
        slot_idx = addr[ADDR_W-1:SLOT_OFF_W];
        slot_ok  = int'(slot_idx) < NUM_CORES;
        off_al   = addr[SLOT_OFF_W-1:0] & ~SLOT_OFF_W'((nb > 0) ? nb - 1 : 0);
    end

    // Lane steering: value byte (nb-1-j) lands at slot byte off_al+j.
    always_comb begin
        byte_en  = '0;
        byte_val = '0;
        for (int k = 0; k < SLOT_BYTES; k++) begin
            int j;
            j = k - int'(off_al);
            if (j >= 0 && j < nb) begin
                byte_en[k] = 1'b1;
                byte_val[SLOT_BITS-1-8*k -: 8] = 8'(wdata >> (8 * (nb - 1 - j)));
            end
        end
    end

endmodule

// File: rtl/brt_slot_store.sv
module brt_slot_store
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int IDX_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [SLOT_BYTES-1:0] byte_en,
    input  logic [SLOT_BITS-1:0]  byte_val,
    input  logic                  id_wb_en,
    input  logic [31:0]           id_wb_val,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic                  rd_ok,
    input  logic [SLOT_OFF_W-1:0] rd_off,
    input  logic [2:0]            rd_n,
    output slot_t                 merged,
    output logic [31:0]           rdata,
    output logic                  rvalid
);

    slot_t slots [NUM_CORES];
    slot_t cur;
    slot_t commit;
    slot_t rslot;
    logic [31:0] racc;

    always_comb begin
        logic [SLOT_BITS-1:0] v;
        cur = (int'(wr_idx) < NUM_CORES) ? slots[wr_idx] : '0;
        v   = cur;
        for (int k = 0; k < SLOT_BYTES; k++) begin
            if (byte_en[k]) v[SLOT_BITS-1-8*k -: 8] = byte_val[SLOT_BITS-1-8*k -: 8];
        end
        merged = v;
        commit = merged;
        if (id_wb_en) commit.ident = id_wb_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CORES; i++) slots[i] <= slot_init(i);
        end else if (wr_en) begin
            slots[wr_idx] <= commit;
        end
    end

    always_comb begin
        rslot = (rd_ok && int'(rd_idx) < NUM_CORES) ? slots[rd_idx] : '0;
        racc  = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < int'(rd_n)) racc = {racc[23:0], slot_byte(rslot, int'(rd_off) + j)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= racc;
        end
    end

endmodule

// File: rtl/brt_launch_ctl.sv
module brt_launch_ctl
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int IDX_W     = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  slot_t                   merged,
    input  logic [NUM_CORES*32-1:0] core_ident,
    output logic                    id_wb_en,
    output logic [31:0]             id_wb_val,
    output logic [NUM_CORES-1:0]    launch_pulse,
    output launch_t                 launch
);

    logic [NUM_CORES-1:0] launched_q;
    logic                 fire;

    always_comb begin
        fire      = wr_en && !merged.entry_addr[0] && !launched_q[wr_idx];
        id_wb_en  = fire;
        id_wb_val = core_ident[int'(wr_idx)*32 +: 32];
    end

    // One launched flag per core: set on release, cleared when the hold bit returns.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                launched_q[g] <= 1'b0;
            end else if (wr_en && int'(wr_idx) == g) begin
                if (merged.entry_addr[0]) launched_q[g] <= 1'b0;
                else if (fire)            launched_q[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            launch_pulse <= '0;
            launch       <= '0;
        end else begin
            launch_pulse <= '0;
            if (fire) begin
                launch_pulse[wr_idx] <= 1'b1;
                launch.start         <= merged.entry_addr & WIN_MASK;
                launch.map_base      <= merged.entry_addr & ~WIN_MASK;
                launch.map_size      <= WIN_SIZE;
                launch.arg           <= merged.arg;
                launch.page_code     <= page_code(WIN_SIZE);
            end
        end
    end

endmodule

// File: rtl/brt_boot_release_table.sv
module brt_boot_release_table
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int ADDR_W   = IDX_W + SLOT_OFF_W,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic [CNT_W-1:0]        cores_present,
    input  logic [NUM_CORES*32-1:0] core_ident,
    output logic [NUM_CORES-1:0]    rel_pulse,
    output logic [63:0]             rel_start,
    output logic [63:0]             rel_arg,
    output logic [63:0]             rel_map_base,
    output logic [63:0]             rel_map_size,
    output logic [3:0]              rel_page_code
);

    logic [IDX_W-1:0]      slot_idx;
    logic                  slot_ok;
    logic [SLOT_OFF_W-1:0] off_al;
    logic [2:0]            nbytes;
    logic [SLOT_BYTES-1:0] byte_en;
    logic [SLOT_BITS-1:0]  byte_val;
    logic                  wr_ok;
    logic                  rd_req;
    logic                  id_wb_en;
    logic [31:0]           id_wb_val;
    slot_t                 merged;
    launch_t               launch;

    brt_bus_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) dec_i (
        .addr     (bus_addr),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .slot_idx (slot_idx),
        .slot_ok  (slot_ok),
        .off_al   (off_al),
        .nbytes   (nbytes),
        .byte_en  (byte_en),
        .byte_val (byte_val)
    );

    // Slot 0 belongs to the primary core; slots of absent cores are read-only.
    always_comb begin
        wr_ok  = bus_req && bus_we && slot_ok && (slot_idx != '0)
                 && (int'(slot_idx) < int'(cores_present)) && (nbytes != 3'd0);
        rd_req = bus_req && !bus_we;
    end

    brt_slot_store #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ok),
        .wr_idx    (slot_idx),
        .byte_en   (byte_en),
        .byte_val  (byte_val),
        .id_wb_en  (id_wb_en),
        .id_wb_val (id_wb_val),
        .rd_en     (rd_req),
        .rd_idx    (slot_idx),
        .rd_ok     (slot_ok),
        .rd_off    (off_al),
        .rd_n      (nbytes),
        .merged    (merged),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    brt_launch_ctl #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) launch_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_ok),
        .wr_idx       (slot_idx),
        .merged       (merged),
        .core_ident   (core_ident),
        .id_wb_en     (id_wb_en),
        .id_wb_val    (id_wb_val),
        .launch_pulse (rel_pulse),
        .launch       (launch)
    );

    assign rel_start     = launch.start;
    assign rel_arg       = launch.arg;
    assign rel_map_base  = launch.map_base;
    assign rel_map_size  = launch.map_size;
    assign rel_page_code = launch.page_code;

endmodule

// File: rtl/brt_checker.sv
module brt_checker
    import brt_pkg::*;
#(
    parameter int NUM_CORES = 32,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int ADDR_W   = IDX_W + SLOT_OFF_W,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [1:0]           bus_size,
    input logic                 bus_rvalid,
    input logic [CNT_W-1:0]     cores_present,
    input logic [NUM_CORES-1:0] rel_pulse,
    input logic [63:0]          rel_start,
    input logic [63:0]          rel_map_base,
    input logic [63:0]          rel_map_size
);

    logic [IDX_W-1:0] chk_idx;
    assign chk_idx = bus_addr[ADDR_W-1:SLOT_OFF_W];

    a_r7_one_core_at_a_time: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rel_pulse));

    a_r7_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
        (|rel_pulse) |-> $past(bus_req && bus_we));

    a_r2_read_valid_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    a_r5_primary_dropped: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && chk_idx == '0) |=> (rel_pulse == '0));

    a_r6_absent_dropped: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && int'(chk_idx) >= int'(cores_present)) |=> (rel_pulse == '0));

    a_r11_bad_size_dropped: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_size == 2'd3) |=> (rel_pulse == '0));

    a_r8_window_split: assert property (@(posedge clk) disable iff (rst)
        (|rel_pulse) |-> (rel_start[63:WIN_SHIFT] == '0 && rel_map_base[WIN_SHIFT-1:0] == '0
                          && rel_map_size == WIN_SIZE));

    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (|rel_pulse) |=> ((rel_pulse & $past(rel_pulse)) == '0));

endmodule

bind brt_boot_release_table brt_checker #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_rvalid    (bus_rvalid),
    .cores_present (cores_present),
    .rel_pulse     (rel_pulse),
    .rel_start     (rel_start),
    .rel_map_base  (rel_map_base),
    .rel_map_size  (rel_map_size)
);

// File: tb/brt_boot_release_table_tb.sv
module brt_boot_release_table_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_req, bus_we;
    logic [9:0]    bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [5:0]    cores_present;
    logic [N*32-1:0] core_ident;
    logic [N-1:0]  rel_pulse;
    logic [63:0]   rel_start, rel_arg, rel_map_base, rel_map_size;
    logic [3:0]    rel_page_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [7:0] sh [N][32];
    bit         launched [N];

    brt_boot_release_table #(.NUM_CORES(N)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cores_present(cores_present), .core_ident(core_ident),
        .rel_pulse(rel_pulse), .rel_start(rel_start), .rel_arg(rel_arg),
        .rel_map_base(rel_map_base), .rel_map_size(rel_map_size),
        .rel_page_code(rel_page_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ident_of(input int i);
        return 32'h5A00_0000 | 32'(i * 257);
    endfunction

    function automatic int nb_of(input int sz);
        case (sz)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] field64(input int idx, input int base);
        logic [63:0] v = '0;
        for (int j = 0; j < 8; j++) v = {v[55:0], sh[idx][base + j]};
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < 32; k++) sh[i][k] = 8'h00;
            sh[i][7]  = 8'h01;
            sh[i][15] = 8'(i);
            sh[i][23] = 8'(i);
            launched[i] = 0;
        end
    endtask

    task automatic do_write(input int idx, input int off, input int sz, input logic [31:0] val, input string tag);
        int n, o;
        bit fire;
        logic [63:0] a, exp_start, exp_base, exp_arg;
        logic [N-1:0] exp_pulse;
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 10'(idx * 32 + off);
        bus_size = 2'(sz); bus_wdata = val;
        n = nb_of(sz);
        fire = 0; exp_start = '0; exp_base = '0; exp_arg = '0;
        if (n > 0 && idx != 0 && idx < int'(cores_present)) begin
            o = off & ~(n - 1);
            for (int j = 0; j < n; j++) sh[idx][o + j] = 8'(val >> (8 * (n - 1 - j)));
            a = field64(idx, 0);
            if (!a[0] && !launched[idx]) begin
                fire = 1;
                launched[idx] = 1;
                exp_start = a & 64'h0000_0000_03FF_FFFF;
                exp_base  = a & ~64'h0000_0000_03FF_FFFF;
                exp_arg   = field64(idx, 8);
                for (int j = 0; j < 4; j++) sh[idx][20 + j] = 8'(ident_of(idx) >> (8 * (3 - j)));
            end else if (a[0]) begin
                launched[idx] = 0;
            end
        end
        exp_pulse = fire ? (N'(1) << idx) : '0;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        check(rel_pulse == exp_pulse, {tag, " R7 pulse"}, 64'(rel_pulse), 64'(exp_pulse));
        if (fire) begin
            check(rel_start == exp_start, "R8 start", rel_start, exp_start);
            check(rel_map_base == exp_base, "R8 map_base", rel_map_base, exp_base);
            check(rel_arg == exp_arg, "R8 arg", rel_arg, exp_arg);
            check(rel_map_size == 64'h400_0000, "R8 map_size", rel_map_size, 64'h400_0000);
            check(rel_page_code == 4'd8, "R8 page_code", 64'(rel_page_code), 64'd8);
        end
    endtask

    task automatic do_read(input int idx, input int off, input int sz, input string tag);
        int n, o;
        logic [31:0] exp;
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = 10'(idx * 32 + off); bus_size = 2'(sz);
        n = nb_of(sz);
        exp = '0;
        if (n > 0) begin
            o = off & ~(n - 1);
            for (int j = 0; j < n; j++) exp = {exp[23:0], sh[idx][o + j]};
        end
        @(negedge clk);
        bus_req = 0;
        check(bus_rvalid == 1'b1, {tag, " R2 rvalid"}, 64'(bus_rvalid), 64'd1);
        check(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; bus_req = 0; bus_we = 0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
        cores_present = 6'd32;
        for (int i = 0; i < N; i++) core_ident[i*32 +: 32] = ident_of(i);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rel_pulse == '0, "R1 pulse idle after reset", 64'(rel_pulse), 64'd0);
        check(bus_rvalid == 1'b0, "R1 rvalid idle after reset", 64'(bus_rvalid), 64'd0);

        // R1/R4: reset contents read back per field
        do_read(5, 4, 2, "R1 R4 addr low word");
        do_read(5, 0, 2, "R1 addr high word");
        do_read(5, 12, 2, "R1 arg low word");
        do_read(5, 20, 2, "R1 ident word");
        do_read(31, 23, 0, "R1 ident byte core31");
        do_read(9, 16, 2, "R1 resv word");
        do_read(9, 28, 2, "R1 pad word");
        do_read(0, 7, 0, "R1 core0 addr byte");

        // R11: invalid size
        do_read(3, 4, 3, "R11 bad-size read");
        do_write(3, 4, 3, 32'h0, "R11 bad-size write");
        do_read(3, 4, 2, "R11 bad-size left slot");

        // R5: primary core slot
        do_write(0, 4, 2, 32'h0000_1000, "R5 core0 write");
        do_read(0, 4, 2, "R5 core0 unchanged");

        // R6: absent core
        cores_present = 6'd8;
        do_write(10, 4, 2, 32'h0000_2000, "R6 absent write");
        do_read(10, 4, 2, "R6 absent unchanged");
        do_write(8, 12, 2, 32'h1234_5678, "R6 boundary slot 8");
        do_read(8, 12, 2, "R6 boundary unchanged");
        cores_present = 6'd32;

        // R7/R8/R9: release core 3, high word first
        do_write(3, 8, 2, 32'hDEAD_BEEF, "R3 arg high");
        do_write(3, 0, 2, 32'h0000_0001, "R7 addr high");
        do_write(3, 4, 2, 32'h0C12_3458, "R7 release core3");
        do_read(3, 20, 2, "R9 ident written back");

        // R10: re-release only after the hold bit returns
        do_write(3, 4, 2, 32'h0C12_3450, "R10 no repeat");
        do_write(3, 7, 0, 32'h01, "R10 hold again");
        do_write(3, 7, 0, 32'h20, "R10 release again");

        // R3: big-endian halfword, alignment
        do_write(6, 9, 1, 32'h0000_ABCD, "R3 half misaligned");
        do_read(6, 8, 0, "R3 byte 8");
        do_read(6, 9, 0, "R3 byte 9");
        do_read(6, 10, 1, "R3 neighbour half");
        do_read(6, 11, 2, "R2 word aligned down");

        // Random mix
        for (int it = 0; it < 800; it++) begin
            int idx, off, sz;
            if (it % 100 == 50) cores_present = 6'($urandom_range(1, 32));
            if (it % 100 == 0)  cores_present = 6'd32;
            idx = $urandom_range(0, N - 1);
            off = $urandom_range(0, 31);
            sz  = ($urandom_range(0, 15) == 0) ? 3 : $urandom_range(0, 2);
            if ($urandom_range(0, 1) == 1) begin
                if ($urandom_range(0, 2) == 0) off = 4 + $urandom_range(0, 3);
                do_write(idx, off, sz, $urandom(), "R3 random write");
            end else begin
                do_read(idx, off, sz, "R2 random read");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule